// File: doc/BRIEF.md
# External Interrupt Edge-Detect Controller

This block turns up to 24 asynchronous pad lines into edge events that software can act on. Each line first passes through a two-flop synchronizer. It can then be cleaned by a digital glitch filter. The filter accepts a new level only after the input has held that level over a run of sampling ticks. The ticks come from one shared divider of the clock, and each channel has its own length for the run.

Each channel has its own rising-edge enable and falling-edge enable. A detected edge sets a sticky event flag. Software clears a flag by writing a one to it. A flag counts towards an interrupt request only when the channel's request enable is set. The requests are ORed in groups of eight channels: channels 0–7 drive request line 0, channels 8–15 drive line 1 and channels 16–23 drive line 2. Events on a channel are recognized only while that pad's input-buffer qualifier is high.

Software reaches the block through a flat register interface. It has one write port and one combinational read port. The address selects the request enables, rising enables, falling enables, filter enables, the prescaler, the event flags, or a per-channel filter-count write.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, every configuration register reads zero, every flag is clear and all request outputs are low.
- R2: When a channel's rising enable (address 1, bit = channel) is set, a 0-to-1 change of its synchronized level sets its flag (address 5, bit = channel). A 1-to-0 change sets no flag unless the falling enable is also set.
- R3: When a channel's falling enable (address 2, bit = channel) is set, a 1-to-0 change of its synchronized level sets its flag. A 0-to-1 change sets no flag unless the rising enable is also set.
- R4: With both edge enables set, a change in either direction sets the flag.
- R5: With both edge enables clear (the reserved setting), no change of the input ever sets that channel's flag.
- R6: Writing to address 5 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: If an edge is detected on a channel in the same cycle that a clear-by-one write for that channel takes effect, the flag stays set.
- R8: While a channel's input-buffer qualifier `ibe_i` bit is low, no edge on that channel sets its flag.
- R9: With the filter enabled for a channel (address 3), the filtered level changes only on a tick. A tick occurs every 2^P clock cycles, where P is the 4-bit prescaler at address 4. The level changes only after the synchronized input has differed from it on M+1 consecutive ticks. M is the channel's count, written at address 6 as data[3:0]=M and data[12:8]=channel. A shorter pulse produces no event.
- R10: With the filter disabled for a channel, the synchronized input goes straight to edge detection. A flag is then set on the third rising clock edge after the pad changes, whatever the stored count is.
- R11: Flags latch whatever the request enables (address 0) hold. Request output g is high exactly when some channel in 8g..8g+7 has both its flag and its request enable set.
- R12: Addresses 0–3 read back the last value written. Address 4 reads back the low 4 bits of the last write, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | 24 | Asynchronous pad levels, one per channel |
| ibe_i | input | 24 | Per-pad input-buffer qualifier; events are recognized only when high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 24 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 24 | Read data for `rd_addr_i`, combinational |
| irq_o | output | 3 | Grouped interrupt requests, one per eight channels |

## Verification
The hardest case to reach from the ports is the collision between a fresh edge and a clear-by-one write on the same flag in the same cycle. It needs the write strobe to land exactly on the edge that registers the detected transition. The stimulus first sets the flag with one edge. It then toggles the pad at a falling clock edge, counts two rising edges through the synchronizer, and raises the clear write so that it is sampled on the third rising edge. The glitch filter is also driven with a pulse shorter than the required run of ticks and then with a long hold. The long hold is checked both before and after the earliest cycle in which acceptance is possible.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_REQEN  = 3'd0,
        REG_RISE   = 3'd1,
        REG_FALL   = 3'd2,
        REG_FILT   = 3'd3,
        REG_PRESC  = 3'd4,
        REG_FLAGS  = 3'd5,
        REG_FCOUNT = 3'd6
    } eirq_reg_e;

    // channel index position inside a filter-count write
    localparam int FCOUNT_IDX_LSB = 8;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/eirq_tick.sv
module eirq_tick #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PSW-1:0] ps_i,
    output logic           tick_o
);
    localparam int PW = (1 << PSW) - 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } div_t;

    div_t          st_d, st_q;
    logic [PW-1:0] mask;

    always_comb begin
        // low ps_i bits set; ps_i = PW wraps to all ones
        mask     = (PW'(1) << ps_i) - PW'(1);
        st_d     = st_q;
        st_d.cnt = st_q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = ((st_q.cnt & mask) == mask);
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din_i,
    input  logic          fe_i,
    input  logic          tick_i,
    input  logic [CW-1:0] max_i,
    output logic          lvl_o,
    output logic          state_o
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fe_i) begin
            // bypassed: track the input so re-enabling starts clean
            st_d.lvl = din_i;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (din_i == st_q.lvl) begin
                st_d.cnt = '0;
            end else if (st_q.cnt >= max_i) begin
                st_d.lvl = din_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o   = fe_i ? st_q.lvl : din_i;
    assign state_o = st_q.lvl;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NCH = 24,
    parameter int CW  = 4,
    parameter int PSW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [NCH-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    input  logic [NCH-1:0]          flags_i,
    output logic [NCH-1:0]          rd_data_o,
    output logic [NCH-1:0]          req_en_o,
    output logic [NCH-1:0]          rise_en_o,
    output logic [NCH-1:0]          fall_en_o,
    output logic [NCH-1:0]          filt_en_o,
    output logic [PSW-1:0]          presc_o,
    output logic [NCH-1:0][CW-1:0]  maxc_o
);
    localparam int IDXW = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0]         en;
        logic [NCH-1:0]         ree;
        logic [NCH-1:0]         fee;
        logic [NCH-1:0]         fe;
        logic [PSW-1:0]         ps;
        logic [NCH-1:0][CW-1:0] maxc;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic [IDXW-1:0] widx;

    always_comb begin
        cfg_d = cfg_q;
        widx  = wr_data_i[FCOUNT_IDX_LSB +: IDXW];
        if (wr_en_i) begin
            case (eirq_reg_e'(wr_addr_i))
                REG_REQEN:  cfg_d.en  = wr_data_i;
                REG_RISE:   cfg_d.ree = wr_data_i;
                REG_FALL:   cfg_d.fee = wr_data_i;
                REG_FILT:   cfg_d.fe  = wr_data_i;
                REG_PRESC:  cfg_d.ps  = wr_data_i[PSW-1:0];
                REG_FCOUNT: begin
                    if (int'(widx) < NCH) cfg_d.maxc[widx] = wr_data_i[CW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (eirq_reg_e'(rd_addr_i))
            REG_REQEN: rd_data_o = cfg_q.en;
            REG_RISE:  rd_data_o = cfg_q.ree;
            REG_FALL:  rd_data_o = cfg_q.fee;
            REG_FILT:  rd_data_o = cfg_q.fe;
            REG_PRESC: rd_data_o = {{(NCH-PSW){1'b0}}, cfg_q.ps};
            REG_FLAGS: rd_data_o = flags_i;
            default:   rd_data_o = '0;
        endcase
    end

    assign req_en_o  = cfg_q.en;
    assign rise_en_o = cfg_q.ree;
    assign fall_en_o = cfg_q.fee;
    assign filt_en_o = cfg_q.fe;
    assign presc_o   = cfg_q.ps;
    assign maxc_o    = cfg_q.maxc;
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NCH = 24,
    parameter int GRP = 8,
    parameter int CW  = 4,
    parameter int PSW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                pad_i,
    input  logic [NCH-1:0]                ibe_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [NCH-1:0]                wr_data_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [NCH-1:0]                rd_data_o,
    output logic [NCH/GRP-1:0]            irq_o
);
    localparam int NGRP = NCH / GRP;

    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [NCH-1:0] flag;
    } evt_t;

    evt_t                   st_d, st_q;
    logic [NCH-1:0]         sync_lvl, det_lvl, filt_state, edge_evt, clr;
    logic [NCH-1:0]         req_en, rise_en, fall_en, filt_en, flags;
    logic [PSW-1:0]         presc;
    logic [NCH-1:0][CW-1:0] maxc;
    logic                   tick;

    eirq_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_i),
        .q_o   (sync_lvl)
    );

    eirq_tick #(.PSW(PSW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_i   (presc),
        .tick_o (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_flt
        eirq_filter #(.CW(CW)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .din_i   (sync_lvl[i]),
            .fe_i    (filt_en[i]),
            .tick_i  (tick),
            .max_i   (maxc[i]),
            .lvl_o   (det_lvl[i]),
            .state_o (filt_state[i])
        );
    end

    eirq_regs #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .flags_i   (flags),
        .rd_data_o (rd_data_o),
        .req_en_o  (req_en),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .filt_en_o (filt_en),
        .presc_o   (presc),
        .maxc_o    (maxc)
    );

    always_comb begin
        clr      = (wr_en_i && eirq_reg_e'(wr_addr_i) == REG_FLAGS) ? wr_data_i : '0;
        edge_evt = ibe_i & ((det_lvl & ~st_q.prev & rise_en) |
                            (~det_lvl & st_q.prev & fall_en));
        st_d      = st_q;
        st_d.prev = det_lvl;
        // a new event outranks a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | edge_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_o[g] = |(flags[g*GRP +: GRP] & req_en[g*GRP +: GRP]);
    end
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk
    import eirq_pkg::*;
#(
    parameter int NCH  = 24,
    parameter int NGRP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NCH-1:0]    flag,
    input logic [NCH-1:0]    ree,
    input logic [NCH-1:0]    fee,
    input logic [NCH-1:0]    ibe,
    input logic [NCH-1:0]    en,
    input logic [NGRP-1:0]   irq,
    input logic [NCH-1:0]    edge_evt,
    input logic [NCH-1:0]    filt,
    input logic [NCH-1:0]    fe,
    input logic              tick
);
    // R5: a channel with both edges disabled never gets a new flag
    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ~$past(flag) & ~$past(ree | fee)) == '0));

    // R8: no new flag while the pad qualifier was low
    a_r8_ibe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ~$past(flag) & ~$past(ibe)) == '0));

    // R6: a flag only falls after a write to the flag address
    a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag) & ~flag) != '0) |->
        ($past(wr_en) && $past(wr_addr) == ADDR_W'(REG_FLAGS)));

    // R7: every detected event is visible as a flag in the next cycle
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((flag & $past(edge_evt)) == $past(edge_evt)));

    // R11: nothing enabled and flagged means no request
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & flag) == '0) |-> (irq == '0));

    // R9: a filtered level moves only on a tick
    a_r9_filter_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt ^ $past(filt)) & $past(fe)) != '0) |-> $past(tick));
endmodule

bind eirq_ctrl eirq_ctrl_chk #(.NCH(NCH), .NGRP(NGRP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .flag     (flags),
    .ree      (rise_en),
    .fee      (fall_en),
    .ibe      (ibe_i),
    .en       (req_en),
    .irq      (irq_o),
    .edge_evt (edge_evt),
    .filt     (filt_state),
    .fe       (filt_en),
    .tick     (tick)
);

// File: tb/tb_eirq_ctrl.sv
module tb_eirq_ctrl;
    import eirq_pkg::*;

    localparam int NCH = 24;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  pad, ibe, wr_data, rd_data;
    logic            wr_en;
    logic [2:0]      wr_addr, rd_addr;
    logic [2:0]      irq;
    logic [NCH-1:0]  v;
    int              checks = 0;
    int              errors = 0;
    bit              done   = 1'b0;

    always #4 clk = ~clk;

    eirq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pad),
        .ibe_i     (ibe),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    // {rise_en, fall_en, level_before, level_after, flag_expected}
    localparam logic [4:0] VEC [8] = '{
        5'b10_01_1, 5'b10_10_0, 5'b01_10_1, 5'b01_01_0,
        5'b11_01_1, 5'b11_10_1, 5'b00_01_0, 5'b00_10_0
    };

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NCH-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpad(input int ch, input logic val);
        @(negedge clk);
        pad[ch] = val;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pad = '0; ibe = '1; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        waitc(5);
        rst_n = 1'b1;
        waitc(2);

        // R1 reset state
        rd(REG_REQEN, v); chk_eq("R1 reqen", v, 0);
        rd(REG_RISE, v);  chk_eq("R1 rise", v, 0);
        rd(REG_FLAGS, v); chk_eq("R1 flags", v, 0);
        chk_eq("R1 irq", irq, 0);

        // R12 readback
        wr(REG_RISE, 24'hA5A5A5);
        rd(REG_RISE, v);  chk_eq("R12 rise readback", v, 24'hA5A5A5);
        wr(REG_PRESC, 24'h00001F);
        rd(REG_PRESC, v); chk_eq("R12 presc readback", v, 24'h00000F);
        wr(REG_PRESC, 0);

        // R2..R5 edge-select table, one channel per row
        for (int k = 0; k < 8; k++) begin
            automatic int ch = k + 2;
            automatic logic r = VEC[k][4];
            automatic logic f = VEC[k][3];
            automatic string tag = (r && f) ? "R4" : r ? "R2" : f ? "R3" : "R5";
            setpad(ch, VEC[k][2]);
            waitc(5);
            wr(REG_RISE, NCH'(r) << ch);
            wr(REG_FALL, NCH'(f) << ch);
            wr(REG_FLAGS, '1);
            setpad(ch, VEC[k][1]);
            waitc(6);
            rd(REG_FLAGS, v);
            chk_eq(tag, v, 32'(NCH'(VEC[k][0]) << ch));
        end
        wr(REG_RISE, 0); wr(REG_FALL, 0); wr(REG_FLAGS, '1);

        // R6 clear by writing one, zeros ignored
        wr(REG_RISE, 24'h1);
        setpad(0, 1'b1);
        waitc(6);
        rd(REG_FLAGS, v); chk_eq("R2 ch0 rise", v, 1);
        wr(REG_FLAGS, 0);
        rd(REG_FLAGS, v); chk_eq("R6 write zero", v, 1);
        wr(REG_FLAGS, 24'hFFFFFE);
        rd(REG_FLAGS, v); chk_eq("R6 other bits", v, 1);
        wr(REG_FLAGS, 24'h1);
        rd(REG_FLAGS, v); chk_eq("R6 clear", v, 0);

        // R7 edge and clear in the same cycle
        wr(REG_FALL, 24'h1);
        setpad(0, 1'b0);
        waitc(6);
        rd(REG_FLAGS, v); chk_eq("R4 ch0 fall", v, 1);
        @(negedge clk); pad[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = REG_FLAGS; wr_data = 24'h1;
        @(negedge clk); wr_en = 1'b0;
        rd(REG_FLAGS, v); chk_eq("R7 edge beats clear", v, 1);
        wr(REG_FLAGS, 24'h1);
        rd(REG_FLAGS, v); chk_eq("R6 clear after collision", v, 0);
        wr(REG_RISE, 0); wr(REG_FALL, 0);

        // R8 pad qualifier
        ibe[3] = 1'b0;
        wr(REG_RISE, 24'h8);
        setpad(3, 1'b0); waitc(5); wr(REG_FLAGS, '1);
        setpad(3, 1'b1); waitc(6);
        rd(REG_FLAGS, v); chk_eq("R8 qualifier low", v, 0);
        ibe[3] = 1'b1;
        setpad(3, 1'b0); waitc(5);
        setpad(3, 1'b1); waitc(6);
        rd(REG_FLAGS, v); chk_eq("R8 qualifier high", v, 24'h8);
        wr(REG_RISE, 0); wr(REG_FLAGS, '1);

        // R11 latching and grouping
        wr(REG_REQEN, 0);
        wr(REG_RISE, (24'h1 << 12) | (24'h1 << 20));
        setpad(12, 1'b1); setpad(20, 1'b1);
        waitc(6);
        rd(REG_FLAGS, v); chk_eq("R11 latch w/o enable", v, (32'h1 << 12) | (32'h1 << 20));
        chk_eq("R11 irq masked", irq, 0);
        wr(REG_REQEN, 24'h1 << 12);
        chk_eq("R11 group1", irq, 3'b010);
        wr(REG_REQEN, 24'h1 << 11);
        chk_eq("R11 neighbour no flag", irq, 3'b000);
        wr(REG_REQEN, (24'h1 << 12) | (24'h1 << 20) | 24'h1);
        chk_eq("R11 groups 1 and 2", irq, 3'b110);
        wr(REG_REQEN, 0); wr(REG_FLAGS, '1);

        // R9 glitch filter: tick every 4 cycles, 4 ticks needed
        wr(REG_RISE, 24'h2);
        wr(REG_FILT, 24'h2);
        wr(REG_PRESC, 24'h2);
        wr(REG_FCOUNT, (24'd1 << FCOUNT_IDX_LSB) | 24'd3);
        setpad(1, 1'b0); waitc(40); wr(REG_FLAGS, '1);
        setpad(1, 1'b1); waitc(6); setpad(1, 1'b0);
        waitc(40);
        rd(REG_FLAGS, v); chk_eq("R9 short pulse rejected", v, 0);
        setpad(1, 1'b1); waitc(8);
        rd(REG_FLAGS, v); chk_eq("R9 not accepted early", v, 0);
        waitc(30);
        rd(REG_FLAGS, v); chk_eq("R9 long hold accepted", v, 24'h2);

        // R10 bypass ignores the stored count
        wr(REG_FILT, 0);
        setpad(1, 1'b0); waitc(5); wr(REG_FLAGS, '1);
        setpad(1, 1'b1); waitc(4);
        rd(REG_FLAGS, v); chk_eq("R10 bypass direct", v, 24'h2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule